// File: doc/BRIEF.md
# Power-Fail Chip-Enable Gating Controller

This block sits between a memory controller's single active-low chip-enable and four banks of static RAM. In normal operation, two bank-select bits steer the chip-enable to exactly one of four active-low bank enables. The steering path is purely combinational, so the select bits need no setup time ahead of the enable.

A supply-good flag from an external comparator protects the RAM contents when power degrades. After a fault, every bank enable is driven inactive, and a status bit reports that the banks are write-protected.

The block handles the fault differently depending on whether an access is active:
- If no access is active when the fault arrives, protection starts at once.
- If an access is active, it may run to completion on the bank it started on, but only for a bounded number of cycles.

When the supply recovers, the banks stay locked out for a fixed hold period before steering resumes. Both periods are parameters counted in clock cycles. A fast-simulation option divides them down.

Top module: `pfce_gate`

## Requirements
- R1: While `ce_n` is 1 and protection is not in force, all four bits of `bank_en_n` are 1, for every value of `bank_sel`.
- R2: While steering, `ce_n` = 0 drives exactly bit `bank_sel` of `bank_en_n` to 0 and holds the other three bits at 1. `bank_sel` 0, 1, 2 and 3 select bits 0, 1, 2 and 3.
- R3: If the synchronized supply flag drops while steering with `ce_n` = 1, the next state is protection: `bank_en_n` = 4'hF and `wp_active` = 1.
- R4: If the synchronized supply flag drops while steering with `ce_n` = 0, the block enters a grace phase. In that phase:
  - The bank selected at that edge stays low while `ce_n` remains 0.
  - Later changes of `bank_sel` have no effect.
  - The first cycle with `ce_n` = 1 ends the grace phase into protection.
- R5: A grace phase lasts at most the effective grace length. With the bench parameters this is 20 cycles. After that, protection is entered even if `ce_n` is still 0.
- R6: While protected, once the synchronized supply flag is high, the block holds `bank_en_n` = 4'hF for exactly the effective hold length before steering. With the bench parameters this is 50 cycles. A supply drop during the hold restarts the lockout.
- R7: Synchronous reset (`rst` = 1) puts the block in protection: `bank_en_n` = 4'hF and `wp_active` = 1.
- R8: While steering, a change of `bank_sel` or `ce_n` reaches `bank_en_n` within the same cycle, with no register on the path.
- R9: `supply_ok` passes through a two-stage synchronizer. A change that is sampled at one rising edge changes the control state at the second rising edge after it.
- R10: `wp_active` is 1 exactly while outputs are forced high by protection or by the recovery hold. It is 0 while steering and during the grace phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| supply_ok | input | 1 | Asynchronous supply-good flag from an external comparator |
| ce_n | input | 1 | Incoming chip-enable, active low |
| bank_sel | input | 2 | Bank-select bits |
| bank_en_n | output | 4 | Conditioned bank enables, active low |
| wp_active | output | 1 | High while outputs are forced inactive by fault or recovery hold |

## Verification
A control state that is wrong shows at the ports in the same cycle it appears, through one of two signs:
- a bank enable that is low while `wp_active` is high;
- a bank enable that stays at 4'hF during steering.

A counter that is off by one moves the first steered cycle after recovery, or the forced release at the end of the grace phase, by exactly one clock. A grace-phase bank latch that is wrong is exposed as soon as `bank_sel` moves during an extended access. For these reasons, the outputs and the status bit are compared against a behavioural model on every clock. Timeouts and select changes are arranged so that each such fault differs from the model within one cycle.

// File: rtl/pfce_pkg.sv
package pfce_pkg;

  // Control phases of the gating controller
  typedef enum logic [1:0] {
    PF_LOCK    = 2'd0,  // protected, supply not good
    PF_RECOVER = 2'd1,  // protected, counting the recovery hold
    PF_PASS    = 2'd2,  // steering chip-enable to the selected bank
    PF_GRACE   = 2'd3   // fault seen, letting an active access finish
  } pf_state_e;

  // Effective cycle count of a timeout, optionally scaled for simulation
  function automatic int unsigned scale_cycles(input int unsigned base,
                                               input bit fast,
                                               input int unsigned div);
    int unsigned r;
    r = fast ? (base / ((div == 0) ? 1 : div)) : base;
    if (r == 0) r = 1;
    return r;
  endfunction

  // Counter width able to hold values up to max(a,b)-1
  function automatic int unsigned cnt_bits(input int unsigned a,
                                           input int unsigned b);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m < 2) ? 1 : $clog2(m);
  endfunction

  // True when bank idx is the one addressed by an active access
  function automatic logic bank_hit(input logic ce_n,
                                    input int unsigned sel,
                                    input int unsigned idx);
    return (!ce_n) && (sel == idx);
  endfunction

  // Phases in which the status bit reports forced protection
  function automatic logic is_protect(input pf_state_e s);
    return (s == PF_LOCK) || (s == PF_RECOVER);
  endfunction

endpackage

// File: rtl/pfce_sync.sv
module pfce_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  generate
    if (STAGES <= 1) begin : g_single
      logic r1;
      always_ff @(posedge clk) begin
        if (rst) r1 <= 1'b0;
        else     r1 <= d;
      end
      assign q = r1;
    end else begin : g_chain
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d};
      end
      assign q = chain[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/pfce_seq.sv
module pfce_seq
  import pfce_pkg::*;
#(
  parameter int unsigned GRACE = 20,
  parameter int unsigned HOLD  = 50,
  parameter int unsigned CNT_W = 6,
  parameter int unsigned SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sup_ok,
  input  logic             ce_n,
  input  logic [SEL_W-1:0] sel,
  output pf_state_e        state_q,
  output logic [SEL_W-1:0] sel_hold_q,
  output logic             ev_fault_hit,
  output logic             ev_grace_timeout,
  output logic             ev_hold_done
);
  localparam logic [CNT_W-1:0] HOLD_LAST  = CNT_W'(HOLD - 1);
  localparam logic [CNT_W-1:0] GRACE_LAST = CNT_W'(GRACE - 1);

  pf_state_e        state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [SEL_W-1:0] sel_hold_d;
  logic             hold_done, grace_done;

  assign hold_done  = (cnt_q == HOLD_LAST);
  assign grace_done = (cnt_q == GRACE_LAST);

  assign ev_fault_hit     = (state_q == PF_PASS) && !sup_ok;
  assign ev_grace_timeout = (state_q == PF_GRACE) && !ce_n && grace_done;
  assign ev_hold_done     = (state_q == PF_RECOVER) && sup_ok && hold_done;

  always_comb begin
    state_d    = state_q;
    cnt_d      = cnt_q;
    sel_hold_d = sel_hold_q;
    case (state_q)
      PF_LOCK: begin
        cnt_d = '0;
        if (sup_ok) state_d = PF_RECOVER;
      end
      PF_RECOVER: begin
        if (!sup_ok) begin
          state_d = PF_LOCK;
          cnt_d   = '0;
        end else if (hold_done) begin
          state_d = PF_PASS;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      PF_PASS: begin
        cnt_d = '0;
        if (!sup_ok) begin
          if (!ce_n) begin
            state_d    = PF_GRACE;
            sel_hold_d = sel;
          end else begin
            state_d = PF_LOCK;
          end
        end
      end
      PF_GRACE: begin
        if (ce_n || grace_done) begin
          state_d = PF_LOCK;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: begin
        state_d = PF_LOCK;
        cnt_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= PF_LOCK;
      cnt_q      <= '0;
      sel_hold_q <= '0;
    end else begin
      state_q    <= state_d;
      cnt_q      <= cnt_d;
      sel_hold_q <= sel_hold_d;
    end
  end
endmodule

// File: rtl/pfce_decode.sv
module pfce_decode
  import pfce_pkg::*;
#(
  parameter int unsigned SEL_W = 2,
  parameter int unsigned NBANK = 4
) (
  input  pf_state_e        state,
  input  logic             ce_n,
  input  logic [SEL_W-1:0] sel_live,
  input  logic [SEL_W-1:0] sel_hold,
  output logic [NBANK-1:0] bank_en_n
);
  logic             gate_open;
  logic [SEL_W-1:0] eff_sel;

  assign gate_open = (state == PF_PASS) || (state == PF_GRACE);
  assign eff_sel   = (state == PF_GRACE) ? sel_hold : sel_live;

  generate
    for (genvar g = 0; g < NBANK; g++) begin : g_bank
      assign bank_en_n[g] = gate_open
                          ? !bank_hit(ce_n, int'(unsigned'(eff_sel)), g)
                          : 1'b1;
    end
  endgenerate
endmodule

// File: rtl/pfce_gate.sv
module pfce_gate
  import pfce_pkg::*;
#(
  parameter int unsigned GRACE_CYC = 10000,
  parameter int unsigned HOLD_CYC  = 8000000,
  parameter bit          FAST_SIM  = 1'b0,
  parameter int unsigned FAST_DIV  = 1000,
  parameter int unsigned SYNC_STG  = 2,
  parameter int unsigned SEL_W     = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    supply_ok,
  input  logic                    ce_n,
  input  logic [SEL_W-1:0]        bank_sel,
  output logic [(1<<SEL_W)-1:0]   bank_en_n,
  output logic                    wp_active
);
  localparam int unsigned NBANK     = 1 << SEL_W;
  localparam int unsigned GRACE_EFF = scale_cycles(GRACE_CYC, FAST_SIM, FAST_DIV);
  localparam int unsigned HOLD_EFF  = scale_cycles(HOLD_CYC, FAST_SIM, FAST_DIV);
  localparam int unsigned CNT_W     = cnt_bits(GRACE_EFF, HOLD_EFF);

  logic             sup_ok_s;
  pf_state_e        state;
  logic [SEL_W-1:0] sel_hold;
  logic             ev_fault_hit, ev_grace_timeout, ev_hold_done;
  logic             in_pass, in_grace, in_recover;

  pfce_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (supply_ok),
    .q   (sup_ok_s)
  );

  pfce_seq #(
    .GRACE (GRACE_EFF),
    .HOLD  (HOLD_EFF),
    .CNT_W (CNT_W),
    .SEL_W (SEL_W)
  ) u_seq (
    .clk              (clk),
    .rst              (rst),
    .sup_ok           (sup_ok_s),
    .ce_n             (ce_n),
    .sel              (bank_sel),
    .state_q          (state),
    .sel_hold_q       (sel_hold),
    .ev_fault_hit     (ev_fault_hit),
    .ev_grace_timeout (ev_grace_timeout),
    .ev_hold_done     (ev_hold_done)
  );

  pfce_decode #(.SEL_W(SEL_W), .NBANK(NBANK)) u_dec (
    .state     (state),
    .ce_n      (ce_n),
    .sel_live  (bank_sel),
    .sel_hold  (sel_hold),
    .bank_en_n (bank_en_n)
  );

  assign in_pass    = (state == PF_PASS);
  assign in_grace   = (state == PF_GRACE);
  assign in_recover = (state == PF_RECOVER);
  assign wp_active  = is_protect(state);
endmodule

// File: rtl/pfce_chk.sv
module pfce_chk #(
  parameter int unsigned GRACE = 20,
  parameter int unsigned HOLD  = 50,
  parameter int unsigned SEL_W = 2,
  parameter int unsigned NBANK = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             ce_n,
  input logic [SEL_W-1:0] bank_sel,
  input logic [NBANK-1:0] bank_en_n,
  input logic             wp_active,
  input logic             sup_ok_s,
  input logic             in_pass,
  input logic             in_grace,
  input logic             in_recover,
  input logic             ev_grace_timeout
);
  int unsigned grace_run;
  int unsigned rec_run;

  always_ff @(posedge clk) begin
    if (rst) begin
      grace_run <= 0;
      rec_run   <= 0;
    end else begin
      grace_run <= in_grace ? grace_run + 1 : 0;
      rec_run   <= in_recover ? rec_run + 1 : 0;
    end
  end

  p_idle_all_high_r1: assert property (@(posedge clk) disable iff (rst)
    ce_n |-> (&bank_en_n));

  p_single_bank_r2: assert property (@(posedge clk) disable iff (rst)
    $countones(~bank_en_n) <= 1);

  p_selected_low_r2: assert property (@(posedge clk) disable iff (rst)
    (in_pass && !ce_n) |-> !bank_en_n[bank_sel]);

  p_fault_leaves_pass_r3: assert property (@(posedge clk) disable iff (rst)
    (in_pass && !sup_ok_s) |=> !in_pass);

  p_release_locks_r4: assert property (@(posedge clk) disable iff (rst)
    (in_grace && ce_n) |=> (wp_active && !in_grace));

  p_grace_bounded_r5: assert property (@(posedge clk) disable iff (rst)
    in_grace |-> (grace_run < GRACE));

  p_timeout_locks_r5: assert property (@(posedge clk) disable iff (rst)
    ev_grace_timeout |=> wp_active);

  p_hold_length_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(in_pass) |-> (rec_run == HOLD));

  p_reset_protect_r7: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> wp_active);

  p_protect_forces_r10: assert property (@(posedge clk) disable iff (rst)
    wp_active |-> (&bank_en_n));
endmodule

bind pfce_gate pfce_chk #(
  .GRACE (GRACE_EFF),
  .HOLD  (HOLD_EFF),
  .SEL_W (SEL_W),
  .NBANK (NBANK)
) u_chk (
  .clk              (clk),
  .rst              (rst),
  .ce_n             (ce_n),
  .bank_sel         (bank_sel),
  .bank_en_n        (bank_en_n),
  .wp_active        (wp_active),
  .sup_ok_s         (sup_ok_s),
  .in_pass          (in_pass),
  .in_grace         (in_grace),
  .in_recover       (in_recover),
  .ev_grace_timeout (ev_grace_timeout)
);

// File: tb/test_pfce_gate.sv
module test_pfce_gate;
  localparam int CLK_PERIOD = 10;
  localparam int G_LEN = 20000 / 1000;  // effective grace cycles
  localparam int H_LEN = 50000 / 1000;  // effective hold cycles

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       supply_ok = 1'b0;
  logic       ce_n = 1'b1;
  logic [1:0] bank_sel = 2'd0;
  logic [3:0] bank_en_n;
  logic       wp_active;

  int    n_cmp = 0;
  int    n_bad = 0;
  int    cyc = 0;
  bit    started = 0;
  bit    done = 0;
  string cur_req = "R7";

  // behavioural reference: 0 locked, 1 holding, 2 steering, 3 grace
  int m_mode = 0;
  int m_cnt = 0;
  int m_sel = 0;
  bit m_s1 = 0, m_s2 = 0;

  pfce_gate #(
    .GRACE_CYC (20000),
    .HOLD_CYC  (50000),
    .FAST_SIM  (1'b1),
    .FAST_DIV  (1000)
  ) i_pfce_gate (
    .clk       (clk),
    .rst       (rst),
    .supply_ok (supply_ok),
    .ce_n      (ce_n),
    .bank_sel  (bank_sel),
    .bank_en_n (bank_en_n),
    .wp_active (wp_active)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  always @(posedge clk) begin
    cyc++;
    started = 1;
    if (rst) begin
      m_mode = 0; m_cnt = 0; m_s1 = 0; m_s2 = 0;
    end else begin
      case (m_mode)
        0: if (m_s2) begin m_mode = 1; m_cnt = 0; end
        1: if (!m_s2) m_mode = 0;
           else begin m_cnt++; if (m_cnt == H_LEN) m_mode = 2; end
        2: if (!m_s2) begin
             if (!ce_n) begin m_mode = 3; m_cnt = 0; m_sel = bank_sel; end
             else m_mode = 0;
           end
        default: begin
          m_cnt++;
          if (ce_n || m_cnt == G_LEN) m_mode = 0;
        end
      endcase
      m_s2 = m_s1;
      m_s1 = supply_ok;
    end
    if (cyc > 200000 && !done) begin
      n_bad++;
      $display("FAIL watchdog req=%s actual=%0d cycles expected=under 200000", cur_req, cyc);
      summary();
      $finish;
    end
  end

  // compare against the model between edges, after inputs settle
  always @(negedge clk) begin
    #2;
    if (started) begin
      logic [3:0] exp_en;
      logic       exp_wp;
      exp_en = 4'hF;
      exp_wp = (m_mode <= 1);
      if (m_mode >= 2 && !ce_n) exp_en[(m_mode == 3) ? m_sel : int'(bank_sel)] = 1'b0;
      n_cmp++;
      if (bank_en_n !== exp_en || wp_active !== exp_wp) begin
        n_bad++;
        $display("FAIL %s cycle %0d: actual en=%b wp=%b expected en=%b wp=%b",
                 cur_req, cyc, bank_en_n, wp_active, exp_en, exp_wp);
      end
    end
  end

  task automatic drive(input logic c, input logic [1:0] s, input logic ok);
    @(negedge clk);
    ce_n = c; bank_sel = s; supply_ok = ok;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    cur_req = "R7";                          // reset forces protection
    idle(4);
    rst = 1'b0;
    cur_req = "R6";                          // hold after supply good
    drive(1'b0, 2'd2, 1'b1);
    idle(H_LEN + 8);                         // ends steering bank 2
    cur_req = "R1";
    for (int i = 0; i < 4; i++) begin drive(1'b1, 2'(i), 1'b1); idle(1); end
    cur_req = "R2";
    for (int i = 0; i < 4; i++) begin drive(1'b0, 2'(i), 1'b1); idle(1); end
    cur_req = "R8";                          // same-cycle select and enable changes
    for (int i = 0; i < 8; i++) drive(i[0], 2'(3 - (i % 4)), 1'b1);
    cur_req = "R3";
    drive(1'b1, 2'd1, 1'b0);
    idle(8);
    cur_req = "R10";                         // enable ignored while protected
    drive(1'b0, 2'd1, 1'b0);
    idle(4);
    cur_req = "R6";
    drive(1'b1, 2'd0, 1'b1);
    idle(H_LEN + 6);
    cur_req = "R4";                          // access finishes on latched bank
    drive(1'b0, 2'd1, 1'b0);
    idle(6);
    drive(1'b0, 2'd3, 1'b0);
    idle(3);
    drive(1'b1, 2'd3, 1'b0);
    idle(2);
    drive(1'b0, 2'd3, 1'b0);
    idle(3);
    cur_req = "R6";
    drive(1'b1, 2'd0, 1'b1);
    idle(H_LEN + 6);
    cur_req = "R5";                          // access outlasts the grace window
    drive(1'b0, 2'd0, 1'b0);
    idle(G_LEN + 10);
    cur_req = "R6";                          // drop during hold restarts it
    drive(1'b0, 2'd2, 1'b1);
    idle(20);
    drive(1'b0, 2'd2, 1'b0);
    idle(4);
    drive(1'b0, 2'd2, 1'b1);
    idle(H_LEN + 6);
    cur_req = "R9";                          // one-cycle dip through synchronizer
    drive(1'b1, 2'd1, 1'b0);
    drive(1'b1, 2'd1, 1'b1);
    idle(4);
    drive(1'b0, 2'd1, 1'b1);
    idle(H_LEN + 6);
    done = 1;
    summary();
    $finish;
  end
endmodule